// File: doc/BRIEF.md
# PCI I/O Base Address Decoder

This block holds the I/O base address register of a PCI type-0 configuration header and performs the target-side address match that uses it. The host reads and writes the header through a dword-indexed configuration port with byte enables. It programs the upper address bits of a fixed-size I/O window and sets the I/O enable bit in the command register. It can also size the window by writing all ones and reading the register back. The identification and class dwords of the header return constant values.

On the bus side, the block watches for the first clock of a transaction. That clock comes after a cycle with the transaction strobe low and has the strobe high. If the command code is I/O read or I/O write, I/O decoding is enabled, and the upper address bits equal the stored base, the block claims the access on its device-select output. The window is 2^BASE_LSB bytes, which is 32 bytes by default. The stored base is kept across reset, so a reset only disables decoding until the host sets I/O enable again.

Top module: `pci_io_bar_decode`

## Requirements
- R1: After reset, `dev_sel` is 0 and the command dword (index 1) reads 0, so I/O enable is cleared.
- R2: The base register at index 4 (offset 10h) reads as {base[31:5], 4'b0000, 1'b1}. Bits 4 to 1 always read 0 and bit 0 always reads 1, whatever is written. After writing FFFF_FFFFh it reads FFFF_FFE1h.
- R3: A write to index 4 changes a base bit only when the byte enable of that bit's byte (cfg_be[n] for bits 8n+7..8n) is set.
- R4: The stored base reads 0 until it is first written and is unchanged by reset.
- R5: Command dword bit 0 is I/O enable. It is written from cfg_wdata[0] only when cfg_be[0] is set, and every other bit of that dword reads 0.
- R6: Index 0 reads {DEVICE_ID, VENDOR_ID}. Index 2 reads 0200_0000h: base class 02h in bits 31:24, with sub-class, programming interface and revision all 00h. Index 3 reads 0, so the header type byte in bits 23:16 is 00h. All other indices read 0.
- R7: `cfg_rvalid` is high, with `cfg_rdata` valid, exactly in the cycle after a read request (cfg_req=1, cfg_we=0) is sampled. Writes never raise it.
- R8: An address phase is a clock edge with `bus_frame` high where the previous edge saw it low. `dev_sel` rises after that edge when I/O enable is 1, `bus_cbe` is 0010b or 0011b, and bus_ad[31:5] equals the base.
- R9: No claim is made when I/O enable is 0, for any other command code, for any address bit mismatch in 31:5, or on later edges of a transaction that was not claimed in its address phase.
- R10: Once claimed, `dev_sel` stays high while `bus_frame` stays high, whatever the address lines carry. It drops after the first edge that sees `bus_frame` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 6 | Dword index into the header |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| bus_frame | input | 1 | Transaction strobe, active high |
| bus_ad | input | 32 | Address lines |
| bus_cbe | input | 4 | Command code in the address phase |
| dev_sel | output | 1 | Registered device-select claim |

## Verification
On every cycle, the assertions check the following:
- A claim only ever rises after an edge that saw the strobe high, I/O enable set and an I/O command.
- A low strobe always releases the claim.
- Fixed bits of the base register read back correctly.
- Read-valid follows a read request by exactly one cycle.
- The base stays put unless it is written.

Only the bench's sweeps can show the rest. These cover the full address comparison: every single-bit mismatch and low-bit offsets inside the window. They also cover every command code, byte-lane masking on writes, and base retention across reset. The exact constant values of the identification dwords are checked there too.

// File: rtl/iobar_pkg.sv
package iobar_pkg;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int CFG_IDX_W = 6;

  localparam logic [3:0] CMD_IO_RD = 4'b0010;
  localparam logic [3:0] CMD_IO_WR = 4'b0011;

  localparam logic [CFG_IDX_W-1:0] IDX_IDENT = 6'd0;
  localparam logic [CFG_IDX_W-1:0] IDX_CMD   = 6'd1;
  localparam logic [CFG_IDX_W-1:0] IDX_CLASS = 6'd2;
  localparam logic [CFG_IDX_W-1:0] IDX_MISC  = 6'd3;
  localparam logic [CFG_IDX_W-1:0] IDX_BAR   = 6'd4;

  typedef struct packed {
    logic                 req;
    logic                 we;
    logic [CFG_IDX_W-1:0] idx;
    logic [BE_W-1:0]      be;
    logic [DATA_W-1:0]    wdata;
  } cfg_cmd_t;
endpackage

// File: rtl/iobar_cfg_regs.sv
module iobar_cfg_regs
  import iobar_pkg::*;
#(
  parameter int BASE_LSB = 5,
  localparam int BASE_W  = DATA_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_cmd_t          cfg,
  output logic              io_en,
  output logic [BASE_W-1:0] base
);
  logic              bar_wr;
  logic              cmd_wr;
  logic [DATA_W-1:0] lane_mask;
  logic [BASE_W-1:0] base_q = '0;
  logic              io_en_q;

  assign bar_wr = cfg.req && cfg.we && (cfg.idx == IDX_BAR);
  assign cmd_wr = cfg.req && cfg.we && (cfg.idx == IDX_CMD);

  always_comb begin
    for (int b = 0; b < BE_W; b++) lane_mask[b*8 +: 8] = {8{cfg.be[b]}};
  end

  // Base has no reset: it keeps its value across reset.
  always_ff @(posedge clk) begin
    if (bar_wr)
      base_q <= (base_q & ~lane_mask[DATA_W-1:BASE_LSB]) |
                (cfg.wdata[DATA_W-1:BASE_LSB] & lane_mask[DATA_W-1:BASE_LSB]);
  end

  always_ff @(posedge clk) begin
    if (rst)                      io_en_q <= 1'b0;
    else if (cmd_wr && cfg.be[0]) io_en_q <= cfg.wdata[0];
  end

  assign io_en = io_en_q;
  assign base  = base_q;

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
    !bar_wr |=> $stable(base_q)); // R4
  AST_IOEN_HELD: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && cfg.be[0]) |=> $stable(io_en_q)); // R5
endmodule

// File: rtl/iobar_cfg_read.sv
module iobar_cfg_read
  import iobar_pkg::*;
#(
  parameter int          BASE_LSB   = 5,
  parameter logic [15:0] VENDOR_ID  = 16'h0EE1,
  parameter logic [15:0] DEVICE_ID  = 16'h0001,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [7:0]  PROG_IF    = 8'h00,
  parameter logic [7:0]  SUB_CLASS  = 8'h00,
  parameter logic [7:0]  BASE_CLASS = 8'h02,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  localparam int         BASE_W     = DATA_W - BASE_LSB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_req,
  input  logic [CFG_IDX_W-1:0] idx,
  input  logic                 io_en,
  input  logic [BASE_W-1:0]    base,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid
);
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    unique case (idx)
      IDX_IDENT: rd_mux = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:   rd_mux = {{(DATA_W-1){1'b0}}, io_en};
      IDX_CLASS: rd_mux = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
      IDX_MISC:  rd_mux = {8'h00, HDR_TYPE, 16'h0000};
      IDX_BAR:   rd_mux = {base, {(BASE_LSB-1){1'b0}}, 1'b1};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_mux;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rvalid_q |-> $past(rd_req)); // R7
  AST_BAR_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    (rvalid_q && $past(idx) == IDX_BAR) |-> rdata_q[BASE_LSB-1:0] == 1); // R2
endmodule

// File: rtl/iobar_addr_match.sv
module iobar_addr_match
  import iobar_pkg::*;
#(
  parameter int BASE_LSB = 5,
  localparam int BASE_W  = DATA_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_en,
  input  logic [BASE_W-1:0] base,
  input  logic              bus_frame,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [3:0]        bus_cbe,
  output logic              dev_sel
);
  logic frame_q;
  logic addr_phase;
  logic io_cmd;
  logic hit;
  logic sel_q;

  assign addr_phase = bus_frame && !frame_q;
  assign io_cmd     = (bus_cbe == CMD_IO_RD) || (bus_cbe == CMD_IO_WR);
  assign hit        = io_en && io_cmd && (bus_ad[DATA_W-1:BASE_LSB] == base);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      frame_q <= bus_frame;
      if (addr_phase)     sel_q <= hit;
      else if (!bus_frame) sel_q <= 1'b0;
    end
  end

  assign dev_sel = sel_q;

  AST_CLAIM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_q) |-> $past(io_en)); // R9
  AST_CLAIM_IO_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_q) |-> ($past(bus_frame) && $past(bus_cbe[3:1]) == 3'b001)); // R8
  AST_RELEASE_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_frame |=> !sel_q); // R10
endmodule

// File: rtl/pci_io_bar_decode.sv
module pci_io_bar_decode
  import iobar_pkg::*;
#(
  parameter int          BASE_LSB  = 5,
  parameter logic [15:0] VENDOR_ID = 16'h0EE1,
  parameter logic [15:0] DEVICE_ID = 16'h0001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_req,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [BE_W-1:0]      cfg_be,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 cfg_rvalid,
  input  logic                 bus_frame,
  input  logic [DATA_W-1:0]    bus_ad,
  input  logic [3:0]           bus_cbe,
  output logic                 dev_sel
);
  localparam int BASE_W = DATA_W - BASE_LSB;

  cfg_cmd_t          cfg;
  logic              io_en;
  logic [BASE_W-1:0] base;

  assign cfg = '{req: cfg_req, we: cfg_we, idx: cfg_idx, be: cfg_be, wdata: cfg_wdata};

  iobar_cfg_regs #(.BASE_LSB(BASE_LSB)) u_regs (
    .clk(clk), .rst(rst), .cfg(cfg), .io_en(io_en), .base(base)
  );

  iobar_cfg_read #(
    .BASE_LSB(BASE_LSB), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
  ) u_read (
    .clk(clk), .rst(rst), .rd_req(cfg_req && !cfg_we), .idx(cfg_idx),
    .io_en(io_en), .base(base), .rdata(cfg_rdata), .rvalid(cfg_rvalid)
  );

  iobar_addr_match #(.BASE_LSB(BASE_LSB)) u_match (
    .clk(clk), .rst(rst), .io_en(io_en), .base(base), .bus_frame(bus_frame),
    .bus_ad(bus_ad), .bus_cbe(bus_cbe), .dev_sel(dev_sel)
  );
endmodule

// File: tb/tb_pci_io_bar_decode.sv
`timescale 1ns/1ps
module tb_pci_io_bar_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        bus_frame = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe = '0;
  logic        dev_sel;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pci_io_bar_decode dut (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .bus_frame(bus_frame), .bus_ad(bus_ad),
    .bus_cbe(bus_cbe), .dev_sel(dev_sel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be,
                           input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    check(cfg_rvalid == 0, "R7 write raised rvalid", {31'b0, cfg_rvalid}, 0);
    cfg_req = 0; cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_idx = idx;
    @(negedge clk);
    check(cfg_rvalid == 1, "R7 rvalid after read", {31'b0, cfg_rvalid}, 1);
    d = cfg_rdata;
    cfg_req = 0;
    @(negedge clk);
    check(cfg_rvalid == 0, "R7 rvalid single cycle", {31'b0, cfg_rvalid}, 0);
  endtask

  task automatic expect_rd(input logic [5:0] idx, input logic [31:0] exp,
                           input string req);
    logic [31:0] d;
    cfg_read(idx, d);
    check(d === exp, req, d, exp);
  endtask

  // One transaction: idle edge, address phase, one more strobe edge, release.
  task automatic bus_access(input logic [31:0] ad, input logic [3:0] cbe,
                            input bit exp);
    @(negedge clk);
    bus_frame = 0;
    @(negedge clk);
    bus_frame = 1; bus_ad = ad; bus_cbe = cbe;
    @(negedge clk);
    check(dev_sel == exp, "R8/R9 claim", {31'b0, dev_sel}, {31'b0, exp});
    bus_ad = ~ad; bus_cbe = 4'h7;
    @(negedge clk);
    check(dev_sel == exp, "R10 hold while strobe high", {31'b0, dev_sel}, {31'b0, exp});
    bus_frame = 0; bus_ad = '0;
    @(negedge clk);
    check(dev_sel == 0, "R10 release", {31'b0, dev_sel}, 0);
  endtask

  task automatic sweep(input logic [26:0] base);
    logic [31:0] a;
    a = {base, 5'b0};
    for (int off = 0; off < 32; off += 5) begin
      bus_access(a | off, 4'b0010, 1);        // R8 I/O read hit
      bus_access(a | off, 4'b0011, 1);        // R8 I/O write hit
    end
    for (int j = 5; j < 32; j++)
      bus_access(a ^ (32'h1 << j), 4'b0010, 0); // R9 mismatch
    for (int c = 0; c < 16; c++)
      bus_access(a, c[3:0], (c == 2) || (c == 3)); // R9 command codes
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(dev_sel == 0, "R1 dev_sel after reset", {31'b0, dev_sel}, 0);
    expect_rd(6'd1, 32'h0, "R1 command after reset");
    expect_rd(6'd4, 32'h1, "R4 base zero before first write");

    // R6 constant dwords
    expect_rd(6'd0, 32'h0001_0EE1, "R6 ident");
    expect_rd(6'd2, 32'h0200_0000, "R6 class");
    expect_rd(6'd3, 32'h0, "R6 header type");
    expect_rd(6'd5, 32'h0, "R6 unused index");
    expect_rd(6'd63, 32'h0, "R6 top index");
    cfg_write(6'd2, 4'hF, 32'hFFFF_FFFF);
    expect_rd(6'd2, 32'h0200_0000, "R6 class ignores write");

    // R9 disabled decode with base zero
    bus_access(32'h0000_0004, 4'b0010, 0);

    // R5 command register
    cfg_write(6'd1, 4'hE, 32'hFFFF_FFFF);
    expect_rd(6'd1, 32'h0, "R5 enable needs be[0]");
    cfg_write(6'd1, 4'hF, 32'hFFFF_FFFF);
    expect_rd(6'd1, 32'h1, "R5 only bit 0 stored");

    // R2 sizing
    cfg_write(6'd4, 4'hF, 32'hFFFF_FFFF);
    expect_rd(6'd4, 32'hFFFF_FFE1, "R2 sizing readback");
    cfg_write(6'd4, 4'hF, 32'h0000_001E);
    expect_rd(6'd4, 32'h0000_0001, "R2 low bits ignore writes");

    // R8 base zero sweep
    sweep(27'h0);

    // R3 byte lanes
    cfg_write(6'd4, 4'hF, 32'h1234_5660);
    for (int b = 0; b < 16; b++) begin
      logic [31:0] m, e;
      m = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
      e = ((32'h1234_5660 & ~m) | (32'hA5C3_96FF & m)) & 32'hFFFF_FFE0;
      cfg_write(6'd4, b[3:0], 32'hA5C3_96FF);
      expect_rd(6'd4, e | 32'h1, "R3 byte lane write");
      cfg_write(6'd4, 4'hF, 32'h1234_5660);
    end

    cfg_write(6'd4, 4'hF, 32'hB6D2_4F40);
    sweep(27'h5B6_927A);
    cfg_write(6'd4, 4'hF, 32'hFFFF_FFE0);
    sweep(27'h7FF_FFFF);

    // R9 late match on an unclaimed transaction
    cfg_write(6'd4, 4'hF, 32'h0000_1000);
    @(negedge clk); bus_frame = 0;
    @(negedge clk); bus_frame = 1; bus_ad = 32'h0000_2000; bus_cbe = 4'b0010;
    @(negedge clk);
    check(dev_sel == 0, "R9 first edge mismatch", {31'b0, dev_sel}, 0);
    bus_ad = 32'h0000_1000;
    @(negedge clk);
    check(dev_sel == 0, "R9 no claim after address phase", {31'b0, dev_sel}, 0);
    bus_frame = 0;

    // R9 enable off
    cfg_write(6'd1, 4'h1, 32'h0);
    bus_access(32'h0000_1000, 4'b0011, 0);
    cfg_write(6'd1, 4'h1, 32'h1);
    bus_access(32'h0000_1008, 4'b0011, 1);

    // R4 base survives reset, R1 enable cleared
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    expect_rd(6'd4, 32'h0000_1001, "R4 base kept over reset");
    expect_rd(6'd1, 32'h0, "R1 enable cleared by reset");
    bus_access(32'h0000_1000, 4'b0010, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule